// File: doc/BRIEF.md
# VME Configuration Register Window Decoder

This block is a slave-side access controller for a small loader FPGA on a VME card. It watches the address strobe, the two data strobes, the write line, the longword qualifier, the address modifier and the address. It answers only 32-bit accesses that hit a narrow window of longword registers. Host software streams a bitstream for a second FPGA through that window.

Every other request is left untouched so that another slave can answer it. The bus strobes pass through a flip-flop synchroniser. A qualifying request is captured and then judged for exactly one cycle in a decode state. A hit moves to an execute state, which performs the register access and holds DTACK until the master lets go of the data strobes.

A request that matches the base, modifier and width but lands outside the window always drops back to idle. A near-miss therefore never parks the decoder. Each register write is also offered to the downstream loader as a one-cycle strobe with the register index and the data.

Top module: `vme_boot_window`

## Requirements
- R1: After a synchronous reset, vme_dtack_n is high, vme_data_oe is low and every window register reads as zero.
- R2: A request is acknowledged only when address bits [23:20] equal BASE (default 0x8), the modifier equals AM_CODE (default 0x39), vme_lword_n is low and both data strobes are low. A request failing any of these gets no DTACK, and a write that fails changes no register.
- R3: Within the 20-bit offset (address bits [19:0]), only longword-aligned offsets from 0x70000 up to and including 0x70020 are accepted. Offsets below or above that range, or with bits [1:0] not zero, are not acknowledged.
- R4: When the decode state finds no hit, the next state is idle, so a valid request that follows a near-miss is acknowledged normally.
- R5: Once asserted, vme_dtack_n stays low while either synchronised data strobe is low. It returns high within a few cycles after both strobes are high.
- R6: A write stores its data in register (offset-0x70000)/4, and a read returns that register's current value.
- R7: vme_data_oe is high only while an acknowledged read is being answered, and never during writes or unmatched requests.
- R8: Each acknowledged write produces exactly one single-cycle cfg_wr_stb pulse carrying the register index and the written data. Other requests produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, active low |
| vme_write_n | input | 1 | Low for a write, high for a read |
| vme_lword_n | input | 1 | Longword qualifier, low for 32-bit transfers |
| vme_am | input | 6 | Address modifier |
| vme_addr | input | 24 | Byte address |
| vme_data_i | input | 32 | Data from the bus |
| vme_data_o | output | 32 | Read data to the bus |
| vme_data_oe | output | 1 | Data bus driver enable |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| cfg_wr_stb | output | 1 | One-cycle strobe per register write |
| cfg_wr_idx | output | 4 | Index of the written register |
| cfg_wr_data | output | 32 | Data of the written register |

## Verification
The embedded properties check the following on every clock:
- The decode state never lingers after a miss.
- DTACK only falls after a hit, and is held for as long as a data strobe is active.
- The data driver is enabled only during an acknowledged read.
- The write strobe lasts one cycle.

Which request shapes count as hits can only be shown by the bench's scenarios. These include the window edges at 0x70000 and 0x70020, the out-of-range and misaligned offsets, and each wrong qualifier. The scenarios also show that written values read back intact and that a miss leaves the registers untouched.

// File: rtl/vme_win_pkg.sv
package vme_win_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2
   } win_state_e;
endpackage

// File: rtl/vmw_sync.sv
module vmw_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= RST_VAL;
               else     chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[g] <= RST_VAL;
               else     chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/vmw_decode.sv
module vmw_decode #(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned OFF_W   = 20,
   parameter int unsigned AM_W    = 6,
   parameter int unsigned BASE    = 'h8,
   parameter int unsigned AM_CODE = 'h39,
   parameter int unsigned WIN_LO  = 'h70000,
   parameter int unsigned WIN_HI  = 'h70020,
   parameter int unsigned IDX_W   = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [AM_W-1:0]   am,
   input  logic              lword_n,
   input  logic [1:0]        ds_n,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned BASE_W = ADDR_W - OFF_W;

   logic [OFF_W-1:0] offset;
   logic [OFF_W-1:0] rel;
   logic base_ok, am_ok, width_ok, align_ok, range_ok;

   always_comb begin
      offset   = addr[OFF_W-1:0];
      rel      = offset - OFF_W'(WIN_LO);
      base_ok  = addr[ADDR_W-1:OFF_W] == BASE_W'(BASE);
      am_ok    = am == AM_W'(AM_CODE);
      width_ok = !lword_n && (ds_n == 2'b00);
      align_ok = offset[1:0] == 2'b00;
      range_ok = (offset >= OFF_W'(WIN_LO)) && (offset <= OFF_W'(WIN_HI));
      hit      = base_ok && am_ok && width_ok && align_ok && range_ok;
      idx      = rel[IDX_W+1:2];
   end
endmodule

// File: rtl/vmw_regs.sv
module vmw_regs #(
   parameter int unsigned NREG  = 9,
   parameter int unsigned DW    = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [DW-1:0]    wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] mem [NREG];

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_reg
         logic [DW-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)                                r <= '0;
            else if (we && (int'(widx) == g))       r <= wdata;
         end
         assign mem[g] = r;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++)
         if (int'(ridx) == i) rdata = mem[i];
   end
endmodule

// File: rtl/vme_boot_window.sv
module vme_boot_window #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned OFF_W       = 20,
   parameter int unsigned DW          = 32,
   parameter int unsigned AM_W        = 6,
   parameter int unsigned BASE        = 'h8,
   parameter int unsigned AM_CODE     = 'h39,
   parameter int unsigned WIN_LO      = 'h70000,
   parameter int unsigned WIN_HI      = 'h70020,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NREG  = (WIN_HI - WIN_LO) / 4 + 1,
   localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vme_as_n,
   input  logic [1:0]        vme_ds_n,
   input  logic              vme_write_n,
   input  logic              vme_lword_n,
   input  logic [AM_W-1:0]   vme_am,
   input  logic [ADDR_W-1:0] vme_addr,
   input  logic [DW-1:0]     vme_data_i,
   output logic [DW-1:0]     vme_data_o,
   output logic              vme_data_oe,
   output logic              vme_dtack_n,
   output logic              cfg_wr_stb,
   output logic [IDX_W-1:0]  cfg_wr_idx,
   output logic [DW-1:0]     cfg_wr_data
);
   import vme_win_pkg::*;

   generate
      if (WIN_HI < WIN_LO || (WIN_LO % 4) != 0 || SYNC_STAGES < 2 ||
          OFF_W >= ADDR_W || WIN_HI >= (1 << OFF_W) || IDX_W + 2 > OFF_W) begin : g_bad_cfg
         $error("vme_boot_window: inconsistent parameters");
      end
   endgenerate

   // strobe synchroniser: {as_n, ds_n[1:0], write_n}
   logic [3:0] strb_s;
   logic       as_s, wr_n_s;
   logic [1:0] ds_s;

   vmw_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) i_sync (
      .clk (clk),
      .rst (rst),
      .d   ({vme_as_n, vme_ds_n, vme_write_n}),
      .q   (strb_s)
   );
   assign {as_s, ds_s, wr_n_s} = strb_s;

   win_state_e        st, st_nxt;
   logic              armed;
   logic [ADDR_W-1:0] cap_addr;
   logic [AM_W-1:0]   cap_am;
   logic              cap_lword_n;
   logic [1:0]        cap_ds_n;
   logic              cap_wr;
   logic [DW-1:0]     cap_data;
   logic              hit;
   logic [IDX_W-1:0]  hit_idx;
   logic              start;
   logic              reg_we;
   logic [DW-1:0]     reg_rdata;

   assign start = (st == ST_IDLE) && armed && !as_s && (ds_s != 2'b11);

   vmw_decode #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .AM_W(AM_W), .BASE(BASE), .AM_CODE(AM_CODE),
      .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .IDX_W(IDX_W)
   ) i_decode (
      .addr    (cap_addr),
      .am      (cap_am),
      .lword_n (cap_lword_n),
      .ds_n    (cap_ds_n),
      .hit     (hit),
      .idx     (hit_idx)
   );

   always_comb begin
      st_nxt = st;
      case (st)
         ST_IDLE:   if (start) st_nxt = ST_DECODE;
         ST_DECODE: begin
            st_nxt = ST_IDLE;                 // a miss always falls back
            if (hit) st_nxt = ST_EXEC;
         end
         ST_EXEC:   if (ds_s == 2'b11) st_nxt = ST_IDLE;
         default:   st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st          <= ST_IDLE;
         armed       <= 1'b0;
         cap_addr    <= '0;
         cap_am      <= '0;
         cap_lword_n <= 1'b1;
         cap_ds_n    <= 2'b11;
         cap_wr      <= 1'b0;
         cap_data    <= '0;
      end else begin
         st <= st_nxt;
         if (as_s)       armed <= 1'b1;
         else if (start) armed <= 1'b0;
         if (start) begin
            cap_addr    <= vme_addr;
            cap_am      <= vme_am;
            cap_lword_n <= vme_lword_n;
            cap_ds_n    <= ds_s;
            cap_wr      <= !wr_n_s;
            cap_data    <= vme_data_i;
         end
      end
   end

   assign reg_we = (st == ST_DECODE) && hit && cap_wr;

   vmw_regs #(.NREG(NREG), .DW(DW), .IDX_W(IDX_W)) i_regs (
      .clk   (clk),
      .rst   (rst),
      .we    (reg_we),
      .widx  (hit_idx),
      .wdata (cap_data),
      .ridx  (hit_idx),
      .rdata (reg_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_wr_stb  <= 1'b0;
         cfg_wr_idx  <= '0;
         cfg_wr_data <= '0;
      end else begin
         cfg_wr_stb <= reg_we;
         if (reg_we) begin
            cfg_wr_idx  <= hit_idx;
            cfg_wr_data <= cap_data;
         end
      end
   end

   assign vme_dtack_n = (st != ST_EXEC);
   assign vme_data_oe = (st == ST_EXEC) && !cap_wr;
   assign vme_data_o  = vme_data_oe ? reg_rdata : '0;

   // R1: outputs released right after reset
   a_r1_reset_release: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (vme_dtack_n && !vme_data_oe));
   // R2: DTACK only falls after the decoder reported a hit
   a_r2_ack_needs_hit: assert property (@(posedge clk) disable iff (rst)
      $fell(vme_dtack_n) |-> $past(hit));
   // R4: a miss in decode returns to idle with DTACK released
   a_r4_miss_to_idle: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DECODE && !hit) |=> (st == ST_IDLE && vme_dtack_n));
   // R5: DTACK held while a data strobe is still active
   a_r5_hold_ack: assert property (@(posedge clk) disable iff (rst)
      (!vme_dtack_n && ds_s != 2'b11) |=> !vme_dtack_n);
   // R5: DTACK released once both strobes are gone
   a_r5_release_ack: assert property (@(posedge clk) disable iff (rst)
      (!vme_dtack_n && ds_s == 2'b11) |=> vme_dtack_n);
   // R7: driver enabled only on acknowledged reads
   a_r7_oe_read_only: assert property (@(posedge clk) disable iff (rst)
      vme_data_oe |-> (!vme_dtack_n && !cap_wr));
   // R8: write strobe is a single pulse
   a_r8_single_stb: assert property (@(posedge clk) disable iff (rst)
      cfg_wr_stb |=> !cfg_wr_stb);
endmodule

// File: tb/test_vme_boot_window.sv
`timescale 1ns/100ps
module test_vme_boot_window;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        as_n = 1'b1;
   logic [1:0]  ds_n = 2'b11;
   logic        write_n = 1'b1;
   logic        lword_n = 1'b1;
   logic [5:0]  am = '0;
   logic [23:0] addr = '0;
   logic [31:0] data_i = '0;
   logic [31:0] data_o;
   logic        data_oe, dtack_n, wr_stb;
   logic [3:0]  wr_idx;
   logic [31:0] wr_data;

   always #2.5 clk = ~clk;

   vme_boot_window i_vme_boot_window (
      .clk(clk), .rst(rst), .vme_as_n(as_n), .vme_ds_n(ds_n), .vme_write_n(write_n),
      .vme_lword_n(lword_n), .vme_am(am), .vme_addr(addr), .vme_data_i(data_i),
      .vme_data_o(data_o), .vme_data_oe(data_oe), .vme_dtack_n(dtack_n),
      .cfg_wr_stb(wr_stb), .cfg_wr_idx(wr_idx), .cfg_wr_data(wr_data)
   );

   typedef struct {
      logic        ack;
      logic        rd;
      logic [31:0] data;
      logic        oe_bad;
      logic        released;
      string       req;
   } item_t;

   item_t exp_q[$];
   item_t obs_q[$];
   int checks = 0;
   int errors = 0;
   logic [31:0] model [9];
   int stb_cnt = 0;
   logic [3:0]  last_idx;
   logic [31:0] last_data;
   bit done = 0;

   always @(negedge clk) if (wr_stb) begin
      stb_cnt++;
      last_idx  = wr_idx;
      last_data = wr_data;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // driver: pushes expectation, runs the bus cycle, pushes observation
   task automatic vme_cycle(input logic [23:0] a, input logic [5:0] m, input logic lw_n,
                            input logic [1:0] ds, input logic wr, input logic [31:0] wd,
                            input logic exp_ack, input logic [31:0] exp_rd, input string req);
      item_t e, o;
      e.ack = exp_ack; e.rd = !wr; e.data = exp_rd; e.oe_bad = 1'b0; e.released = 1'b1; e.req = req;
      exp_q.push_back(e);
      o.ack = 1'b0; o.rd = !wr; o.data = '0; o.oe_bad = 1'b0; o.released = 1'b0; o.req = req;
      @(negedge clk);
      addr = a; am = m; lword_n = lw_n; write_n = !wr; data_i = wd;
      @(negedge clk); as_n = 1'b0;
      @(negedge clk); ds_n = ds;
      for (int i = 0; i < 12 && !o.ack; i++) begin
         @(negedge clk);
         if (data_oe && (wr || dtack_n)) o.oe_bad = 1'b1;
         if (!dtack_n) begin
            o.ack  = 1'b1;
            o.data = data_o;
            if (!wr && !data_oe) o.oe_bad = 1'b1;
         end
      end
      @(negedge clk);
      if (o.ack && dtack_n) o.ack = 1'b0;     // DTACK must still be held with strobes active
      ds_n = 2'b11; as_n = 1'b1;
      for (int i = 0; i < 12 && !o.released; i++) begin
         @(negedge clk);
         if (data_oe && wr) o.oe_bad = 1'b1;
         if (dtack_n && !data_oe) o.released = 1'b1;
      end
      repeat (2) @(negedge clk);
      obs_q.push_back(o);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         item_t e, o;
         wait (obs_q.size() > 0);
         o = obs_q.pop_front();
         e = exp_q.pop_front();
         check({e.req, " ack"}, 32'(o.ack), 32'(e.ack));
         check({e.req, " R5 release"}, 32'(o.released), 32'(e.released));
         check({e.req, " R7 data drive"}, 32'(o.oe_bad), 32'(e.oe_bad));
         if (e.ack && e.rd) check({e.req, " R6 read data"}, o.data, e.data);
      end
   end

   localparam logic [5:0] AMC = 6'h39;

   initial begin
      repeat (4) @(negedge clk);
      check("R1 dtack idle", 32'(dtack_n), 32'd1);
      check("R1 oe idle", 32'(data_oe), 32'd0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 dtack after reset", 32'(dtack_n), 32'd1);
      for (int i = 0; i < 9; i++) model[i] = '0;

      // R1: all registers read zero
      for (int i = 0; i < 9; i++)
         vme_cycle(24'h870000 + 24'(4*i), AMC, 1'b0, 2'b00, 1'b0, '0, 1'b1, 32'h0, "R1 reset value");

      // R6 / R3: write each register incl. both edges, then read back
      for (int i = 0; i < 9; i++) begin
         model[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_1111);
         vme_cycle(24'h870000 + 24'(4*i), AMC, 1'b0, 2'b00, 1'b1, model[i], 1'b1, '0, "R6 write");
      end
      check("R8 strobe count", 32'(stb_cnt), 32'd9);
      check("R8 last idx", 32'(last_idx), 32'd8);
      check("R8 last data", last_data, model[8]);
      for (int i = 8; i >= 0; i--)
         vme_cycle(24'h870000 + 24'(4*i), AMC, 1'b0, 2'b00, 1'b0, '0, 1'b1, model[i], "R6 R3 readback");

      // R2: each qualifier wrong, as writes that must not land
      vme_cycle(24'h970004, AMC,   1'b0, 2'b00, 1'b1, 32'hDEAD0001, 1'b0, '0, "R2 base");
      vme_cycle(24'h870004, 6'h3D, 1'b0, 2'b00, 1'b1, 32'hDEAD0002, 1'b0, '0, "R2 modifier");
      vme_cycle(24'h870004, AMC,   1'b1, 2'b00, 1'b1, 32'hDEAD0003, 1'b0, '0, "R2 lword");
      vme_cycle(24'h870004, AMC,   1'b0, 2'b01, 1'b1, 32'hDEAD0004, 1'b0, '0, "R2 one strobe");
      check("R8 no strobe on miss", 32'(stb_cnt), 32'd9);
      vme_cycle(24'h870004, AMC, 1'b0, 2'b00, 1'b0, '0, 1'b1, model[1], "R2 register untouched");

      // R3: window edges, R4: valid cycle right after each near-miss
      vme_cycle(24'h870024, AMC, 1'b0, 2'b00, 1'b1, 32'hBAD0_0024, 1'b0, '0, "R3 above window");
      vme_cycle(24'h870020, AMC, 1'b0, 2'b00, 1'b0, '0, 1'b1, model[8], "R4 after miss");
      vme_cycle(24'h86FFFC, AMC, 1'b0, 2'b00, 1'b0, '0, 1'b0, '0, "R3 below window");
      vme_cycle(24'h86FFFC + 24'h10000 - 24'h1FFFC + 24'h10000, AMC, 1'b0, 2'b00, 1'b0, '0,
                1'b1, model[0], "R4 after miss");
      vme_cycle(24'h870006, AMC, 1'b0, 2'b00, 1'b1, 32'hBAD0_0006, 1'b0, '0, "R3 misaligned");
      vme_cycle(24'h87000C, AMC, 1'b0, 2'b00, 1'b0, '0, 1'b1, model[3], "R4 after misaligned");
      check("R8 strobe count after misses", 32'(stb_cnt), 32'd9);

      // R6 overwrite and R8 payload
      model[5] = 32'h1234_5678;
      vme_cycle(24'h870014, AMC, 1'b0, 2'b00, 1'b1, model[5], 1'b1, '0, "R6 overwrite");
      vme_cycle(24'h870014, AMC, 1'b0, 2'b00, 1'b0, '0, 1'b1, model[5], "R6 overwrite read");
      check("R8 idx", 32'(last_idx), 32'd5);
      check("R8 data", last_data, model[5]);
      check("R8 count", 32'(stb_cnt), 32'd10);

      wait (obs_q.size() == 0 && exp_q.size() == 0);
      repeat (5) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule